// File: doc/BRIEF.md
# Flash Configuration Port Responder

This block is the device-side responder that sits behind a JTAG test access port and runs in-system flash configuration commands. An 8-bit instruction register picks one operation. Each operation has its own data register length. For example, it can read the device ID, shift in a flash address, program a 64-bit word, erase sectors by mask, run a blank check, read the option word, or set the security bit. The full 16-state TAP controller is built in, and every register is clocked by TCK.

Before program, erase or blank check are accepted, the port must be placed in configuration mode. Each accepted operation takes a fixed number of TCK cycles, set by a parameter. While it runs, a "done" bit in the status byte reads 0. The host selects the no-op instruction and scans the 8-bit status register until "done" reads 1. Flash storage is modelled as one 64-bit word per sector. Main sectors map to mask bits from 0 upward and secondary sectors map to mask bits from 32 upward.

Top module: `isc_flash_tap`

## Requirements
- R1: After the synchronous reset (trst_n low), the instruction is the no-op 0x10. The 8-bit status byte then reads 0x00. Status layout: bit 6 security, bit 3 configuration mode, bit 2 done, bits 1:0 result (2 = success, 1 = rejected, 0 = cleared).
- R2: Instruction 0xFE selects a 32-bit register that captures the ID_CODE parameter.
- R3: Loading instruction 0x0C sets the mode bit and loading 0x0F clears it.
- R4: An accepted operation clears done and keeps it low for exactly BUSY_CYCLES TCK cycles after its Update-DR (or Update-IR) edge. Done then rises with result 2.
- R5: With the mode bit clear, a program (0x20), erase (0x30) or blank check (0x60) sets done=1 and result=1 at once and changes no stored word or option bit.
- R6: With address 0x50 in the 8-bit address register (instruction 0x11), a 64-bit program stores the word in the option register. Instruction 0x07 reads that register back over 64 bits.
- R7: Programming a sector address (0 to MAIN_SECT-1, or 32 to 32+SEC_SECT-1) ANDs the data into that sector's word. Any other address except 0x50 is rejected with result 1.
- R8: An erase mask sets to all ones the word of every sector whose bit is set (main sector k at bit k, secondary sector k at bit 32+k). Other sectors are left unchanged.
- R9: An erase mask of all ones erases every sector, clears the option register and clears the security bit.
- R10: An erase mask with only bit 49 set clears the option register and leaves every sector word unchanged.
- R11: With address 0x80 loaded and the mode bit set, loading instruction 0x22 starts an operation that sets status bit 6 when it completes.
- R12: A blank check takes a 64-bit sector mask. The next capture under 0x60 returns 1 at each requested sector bit whose word is not all ones, and 0 at every other bit.
- R13: Five TCK cycles with TMS high reset the instruction to 0x10. The option register, the security bit and the mode bit are kept.
- R14: Instruction 0x13 sets the result field to 0 and leaves the mode bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| trst_n | input | 1 | Synchronous active-low reset of the whole block |
| tms | input | 1 | Test mode select, steers the TAP controller |
| tdi | input | 1 | Serial data in, enters the top bit of the selected register |
| tdo | output | 1 | Serial data out, bit 0 of the shift register during shift states |

## Verification
The hardest condition to reach from the pins is a status capture that lands inside the busy window. It needs an instruction reload and a capture to complete within BUSY_CYCLES edges after the operation's update. The bench keeps BUSY_CYCLES at 20. It reloads the no-op instruction right after each update, so the first status capture falls on the 16th edge, while done is still low. The first and last polled status values are then checked separately. Stored sector contents cannot be read directly, so they are observed through blank-check captures taken before and after rejected and partial-mask operations.

// File: rtl/isc_pkg.sv
`timescale 1ns/1ps
// Shared opcodes, TAP state encoding and sector mapping helpers for the
// flash configuration responder. Assumes 8-bit instructions, 64-bit masks.
package isc_pkg;

    localparam logic [7:0] OP_IDCODE   = 8'hFE;
    localparam logic [7:0] OP_CFG_RD   = 8'h07;
    localparam logic [7:0] OP_ENTER    = 8'h0C;
    localparam logic [7:0] OP_LEAVE    = 8'h0F;
    localparam logic [7:0] OP_NOOP     = 8'h10;
    localparam logic [7:0] OP_ADDR     = 8'h11;
    localparam logic [7:0] OP_CLR      = 8'h13;
    localparam logic [7:0] OP_PROG     = 8'h20;
    localparam logic [7:0] OP_PROG_SEC = 8'h22;
    localparam logic [7:0] OP_ERASE    = 8'h30;
    localparam logic [7:0] OP_BLANK    = 8'h60;

    localparam logic [7:0] ADDR_OPTION = 8'h50;
    localparam logic [7:0] ADDR_SECURE = 8'h80;
    localparam int         SEC_BASE    = 32;
    localparam int         OPT_ERASE_BIT = 49;

    localparam logic [1:0] RES_CLEAR = 2'd0;
    localparam logic [1:0] RES_FAIL  = 2'd1;
    localparam logic [1:0] RES_OK    = 2'd2;

    typedef enum logic [3:0] {
        ST_TLR, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_t;

    typedef enum logic [1:0] {
        JOB_PROG, JOB_ERASE, JOB_BLANK, JOB_SECURE
    } job_t;

    // Length of the data register selected by an instruction (bypass is 1).
    function automatic logic [6:0] dr_len(input logic [7:0] op);
        case (op)
            OP_IDCODE:                               return 7'd32;
            OP_CFG_RD, OP_PROG, OP_ERASE, OP_BLANK:  return 7'd64;
            OP_NOOP, OP_ADDR:                        return 7'd8;
            default:                                 return 7'd1;
        endcase
    endfunction

    // Mask bit position of sector s: main sectors first, secondary from bit 32.
    function automatic int sect_pos(input int s, input int main_n);
        return (s < main_n) ? s : SEC_BASE + s - main_n;
    endfunction

endpackage

// File: rtl/isc_tap_fsm.sv
`timescale 1ns/1ps
// TAP controller: standard 16-state walk driven by TMS on each TCK edge.
// Assumes synchronous active-low reset, which forces Test-Logic-Reset.
module isc_tap_fsm
    import isc_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_t state
);

    tap_state_t nxt;

    // Next-state selection from the current state and TMS.
    always_comb begin
        case (state)
            ST_TLR:    nxt = tms ? ST_TLR    : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SHF_IR;
            default:   nxt = tms ? ST_SEL_DR : ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge tck) begin
        if (!rst_n) state <= ST_TLR;
        else        state <= nxt;
    end

endmodule

// File: rtl/isc_scan_path.sv
`timescale 1ns/1ps
// Instruction register and the shared 64-bit shift register. IR scans use
// the low 8 bits; DR scans use the length the instruction selects, with TDI
// entering at bit len-1 and TDO taken from bit 0.
module isc_scan_path
    import isc_pkg::*;
#(
    parameter logic [31:0] ID_CODE = 32'h1C0D_E0A1
) (
    input  logic        tck,
    input  logic        rst_n,
    input  tap_state_t  state,
    input  logic        tdi,
    input  logic [7:0]  status_byte,
    input  logic [63:0] option_q,
    input  logic [63:0] blank_q,
    output logic [7:0]  ir,
    output logic [63:0] sr,
    output logic        tdo
);

    logic [63:0] cap_val;
    logic [63:0] shifted;
    logic [6:0]  len;
    logic [5:0]  top;

    // Parallel value captured into the shift register per instruction.
    always_comb begin
        case (ir)
            OP_IDCODE: cap_val = {32'b0, ID_CODE};
            OP_CFG_RD: cap_val = option_q;
            OP_NOOP:   cap_val = {56'b0, status_byte};
            OP_BLANK:  cap_val = blank_q;
            default:   cap_val = '0;
        endcase
    end

    // One shift step: move right, insert TDI at the top of the active length.
    always_comb begin
        len     = (state == ST_SHF_IR) ? 7'd8 : dr_len(ir);
        top     = 6'(len - 7'd1);
        shifted = sr >> 1;
        shifted[top] = tdi;
    end

    // Instruction register: no-op after reset or Test-Logic-Reset.
    always_ff @(posedge tck) begin
        if (!rst_n || state == ST_TLR) ir <= OP_NOOP;
        else if (state == ST_UPD_IR)   ir <= sr[7:0];
    end

    // Shift register: capture, then shift in the shift states.
    always_ff @(posedge tck) begin
        if (!rst_n) sr <= '0;
        else begin
            case (state)
                ST_CAP_IR:            sr <= 64'h01;
                ST_CAP_DR:            sr <= cap_val;
                ST_SHF_IR, ST_SHF_DR: sr <= shifted;
                default:              sr <= sr;
            endcase
        end
    end

    assign tdo = (state == ST_SHF_DR || state == ST_SHF_IR) ? sr[0] : 1'b0;

endmodule

// File: rtl/isc_flash_core.sv
`timescale 1ns/1ps
// Configuration engine: mode bit, status, address, option word, security,
// sector words and the busy timer. Acts on Update-DR / Update-IR states.
// Assumes MAIN_SECT and SEC_SECT each at most 32 and BUSY_CYCLES >= 1.
module isc_flash_core
    import isc_pkg::*;
#(
    parameter int MAIN_SECT   = 4,
    parameter int SEC_SECT    = 4,
    parameter int BUSY_CYCLES = 20
) (
    input  logic        tck,
    input  logic        rst_n,
    input  tap_state_t  state,
    input  logic [7:0]  ir,
    input  logic [63:0] sr,
    output logic [7:0]  status_byte,
    output logic [63:0] option_q,
    output logic [63:0] blank_q,
    output logic        busy,
    output logic        op_start
);

    localparam int NSECT = MAIN_SECT + SEC_SECT;
    localparam int CW    = $clog2(BUSY_CYCLES + 1);
    localparam logic [7:0] MAIN_END = 8'(MAIN_SECT);
    localparam logic [7:0] SEC_LO   = 8'(SEC_BASE);
    localparam logic [7:0] SEC_END  = 8'(SEC_BASE + SEC_SECT);

    logic          mode_q, done_q, secure_q;
    logic [1:0]    res_q;
    logic [7:0]    addr_q, job_addr_q;
    logic [63:0]   job_data_q;
    logic [CW-1:0] cnt_q;
    job_t          job_q;
    logic [63:0]   words_q [NSECT];
    logic [NSECT-1:0] sect_blank;

    logic upd_dr, upd_ir, want, ok, op_reject, addr_sect;
    job_t want_job;

    // Per-sector erased flag.
    generate
        for (genvar s = 0; s < NSECT; s++) begin : g_blank
            assign sect_blank[s] = &words_q[s];
        end
    endgenerate

    // Decode a request and decide whether it is accepted or rejected.
    always_comb begin
        upd_dr    = (state == ST_UPD_DR);
        upd_ir    = (state == ST_UPD_IR);
        addr_sect = (addr_q < MAIN_END) || (addr_q >= SEC_LO && addr_q < SEC_END);
        want      = 1'b0;
        want_job  = JOB_PROG;
        ok        = mode_q;
        if (upd_dr && ir == OP_PROG) begin
            want = 1'b1; want_job = JOB_PROG;
            ok   = mode_q && (addr_sect || addr_q == ADDR_OPTION);
        end else if (upd_dr && ir == OP_ERASE) begin
            want = 1'b1; want_job = JOB_ERASE;
        end else if (upd_dr && ir == OP_BLANK) begin
            want = 1'b1; want_job = JOB_BLANK;
        end else if (upd_ir && sr[7:0] == OP_PROG_SEC) begin
            want = 1'b1; want_job = JOB_SECURE;
            ok   = mode_q && addr_q == ADDR_SECURE;
        end
        op_start  = !busy && want && ok;
        op_reject = !busy && want && !ok;
    end

    // Control and status state, busy timer and job completion.
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            mode_q <= 1'b0; done_q <= 1'b0; secure_q <= 1'b0; res_q <= RES_CLEAR;
            addr_q <= '0; job_addr_q <= '0; job_data_q <= '0; cnt_q <= '0;
            job_q <= JOB_PROG; busy <= 1'b0; option_q <= '0; blank_q <= '0;
            for (int s = 0; s < NSECT; s++) words_q[s] <= '1;
        end else begin
            if (upd_dr && ir == OP_ADDR)          addr_q <= sr[7:0];
            if (upd_ir && sr[7:0] == OP_ENTER)    mode_q <= 1'b1;
            if (upd_ir && sr[7:0] == OP_LEAVE)    mode_q <= 1'b0;
            if (op_start) begin
                busy <= 1'b1; done_q <= 1'b0; cnt_q <= CW'(BUSY_CYCLES);
                job_q <= want_job; job_data_q <= sr; job_addr_q <= addr_q;
            end
            if (op_reject) begin
                done_q <= 1'b1; res_q <= RES_FAIL;
            end
            if (busy) begin
                if (cnt_q > CW'(1)) cnt_q <= cnt_q - CW'(1);
                else begin
                    busy <= 1'b0; done_q <= 1'b1; res_q <= RES_OK;
                    case (job_q)
                        JOB_PROG: begin
                            if (job_addr_q == ADDR_OPTION) option_q <= job_data_q;
                            for (int s = 0; s < NSECT; s++)
                                if (job_addr_q == 8'(sect_pos(s, MAIN_SECT)))
                                    words_q[s] <= words_q[s] & job_data_q;
                        end
                        JOB_ERASE: begin
                            if (&job_data_q) begin
                                for (int s = 0; s < NSECT; s++) words_q[s] <= '1;
                                option_q <= '0; secure_q <= 1'b0;
                            end else if (job_data_q == (64'd1 << OPT_ERASE_BIT)) begin
                                option_q <= '0;
                            end else begin
                                for (int s = 0; s < NSECT; s++)
                                    if (job_data_q[sect_pos(s, MAIN_SECT)]) words_q[s] <= '1;
                            end
                        end
                        JOB_BLANK: begin
                            blank_q <= '0;
                            for (int s = 0; s < NSECT; s++)
                                blank_q[sect_pos(s, MAIN_SECT)] <=
                                    job_data_q[sect_pos(s, MAIN_SECT)] & !sect_blank[s];
                        end
                        default: secure_q <= 1'b1;
                    endcase
                end
            end
            if (upd_ir && sr[7:0] == OP_CLR) res_q <= RES_CLEAR;
        end
    end

    assign status_byte = {1'b0, secure_q, 2'b00, mode_q, done_q, res_q};

endmodule

// File: rtl/isc_flash_tap.sv
`timescale 1ns/1ps
// Top: TAP controller, scan path and configuration engine for the flash
// configuration port. Assumes one TCK domain and synchronous reset.
module isc_flash_tap
    import isc_pkg::*;
#(
    parameter logic [31:0] ID_CODE     = 32'h1C0D_E0A1,
    parameter int          MAIN_SECT   = 4,
    parameter int          SEC_SECT    = 4,
    parameter int          BUSY_CYCLES = 20
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo
);

    tap_state_t  state;
    logic [7:0]  ir;
    logic [63:0] sr;
    logic [7:0]  status_byte;
    logic [63:0] option_q, blank_q;
    logic        busy, op_start;

    isc_tap_fsm u_fsm (
        .tck(tck), .rst_n(trst_n), .tms(tms), .state(state)
    );

    isc_scan_path #(.ID_CODE(ID_CODE)) u_scan (
        .tck(tck), .rst_n(trst_n), .state(state), .tdi(tdi),
        .status_byte(status_byte), .option_q(option_q), .blank_q(blank_q),
        .ir(ir), .sr(sr), .tdo(tdo)
    );

    isc_flash_core #(
        .MAIN_SECT(MAIN_SECT), .SEC_SECT(SEC_SECT), .BUSY_CYCLES(BUSY_CYCLES)
    ) u_core (
        .tck(tck), .rst_n(trst_n), .state(state), .ir(ir), .sr(sr),
        .status_byte(status_byte), .option_q(option_q), .blank_q(blank_q),
        .busy(busy), .op_start(op_start)
    );

endmodule

// File: rtl/isc_flash_tap_chk.sv
`timescale 1ns/1ps
// Property checker for isc_flash_tap, attached by bind below.
module isc_flash_tap_chk
    import isc_pkg::*;
#(
    parameter int BUSY_CYCLES = 20
) (
    input logic       tck,
    input logic       trst_n,
    input tap_state_t state,
    input logic [7:0] ir,
    input logic [7:0] new_ir,
    input logic [3:0] stat,
    input logic       busy,
    input logic       op_start
);

    int busy_len;

    // Measure the busy window length since the last accepted start.
    always_ff @(posedge tck) begin
        if (!trst_n)       busy_len <= 0;
        else if (op_start) busy_len <= 0;
        else if (busy)     busy_len <= busy_len + 1;
    end

    // R3
    enter_mode_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_UPD_IR && new_ir == OP_ENTER) |=> stat[3]);
    // R3
    leave_mode_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_UPD_IR && new_ir == OP_LEAVE) |=> !stat[3]);
    // R4
    busy_len_chk: assert property (@(posedge tck) disable iff (!trst_n)
        $fell(busy) |-> busy_len == BUSY_CYCLES);
    // R4
    busy_done_chk: assert property (@(posedge tck) disable iff (!trst_n)
        busy |-> !stat[2]);
    // R4
    done_ok_chk: assert property (@(posedge tck) disable iff (!trst_n)
        ($fell(busy) && !$past(state == ST_UPD_IR && new_ir == OP_CLR)) |-> stat[2:0] == 3'b110);
    // R5
    reject_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_UPD_DR && !busy && !stat[3] &&
         (ir == OP_PROG || ir == OP_ERASE || ir == OP_BLANK)) |=> stat[2:0] == 3'b101);
    // R13
    tlr_ir_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_TLR) |=> ir == OP_NOOP);
    // R14
    clear_chk: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_UPD_IR && new_ir == OP_CLR) |=> (stat[1:0] == 2'b00 && $stable(stat[3])));

endmodule

bind isc_flash_tap isc_flash_tap_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
    .tck(tck), .trst_n(trst_n), .state(state), .ir(ir), .new_ir(sr[7:0]),
    .stat(status_byte[3:0]), .busy(busy), .op_start(op_start)
);

// File: tb/isc_flash_tap_bench.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module isc_flash_tap_bench;

    localparam logic [31:0] ID   = 32'h5A17_C0DB;
    localparam logic [63:0] MASK = 64'h0000_000F_0000_000F;
    localparam logic [63:0] OPTV = 64'hA5A5_0000_1234_5678;

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b0, tdi = 1'b0;
    logic tdo;
    int   n_run = 0, n_fail = 0;

    always #10 tck = ~tck;

    isc_flash_tap #(.ID_CODE(ID), .MAIN_SECT(4), .SEC_SECT(4), .BUSY_CYCLES(20))
        u_isc_flash_tap (.tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo));

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, output logic o);
        tms = m; tdi = d;
        #2 o = tdo;
        @(posedge tck); #1;
    endtask

    task automatic ir_load(input logic [7:0] op);
        logic o;
        step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int i = 0; i < 8; i++) step(i == 7, op[i], o);
        step(1, 0, o); step(0, 0, o);
    endtask

    task automatic dr_xfer(input int len, input logic [63:0] din, output logic [63:0] dout);
        logic o;
        dout = '0;
        step(1, 0, o); step(0, 0, o); step(0, 0, o);
        for (int i = 0; i < len; i++) begin
            step(i == len - 1, din[i], o);
            dout[i] = o;
        end
        step(1, 0, o); step(0, 0, o);
    endtask

    task automatic tms_reset();
        logic o;
        for (int i = 0; i < 5; i++) step(1, 0, o);
        step(0, 0, o);
    endtask

    task automatic poll(output logic [7:0] first, output logic [7:0] last);
        logic [63:0] v;
        ir_load(8'h10);
        dr_xfer(8, 0, v);
        first = v[7:0];
        for (int i = 0; i < 40 && !v[2]; i++) dr_xfer(8, 0, v);
        last = v[7:0];
    endtask

    task automatic set_addr(input logic [7:0] a);
        logic [63:0] v;
        ir_load(8'h11); dr_xfer(8, {56'b0, a}, v);
    endtask

    task automatic run_op(input logic [7:0] op, input logic [63:0] d, output logic [7:0] st);
        logic [63:0] v; logic [7:0] f;
        ir_load(op); dr_xfer(64, d, v); poll(f, st);
    endtask

    task automatic blank_read(input logic [63:0] m, output logic [63:0] res);
        logic [7:0] st;
        run_op(8'h60, m, st);
        ir_load(8'h60); dr_xfer(64, m, res);
        poll(st, st);
    endtask

    task automatic t_reset();
        logic [63:0] v;
        trst_n = 0; repeat (3) @(posedge tck); #1;
        trst_n = 1; step(0, 0, v[0]);
        dr_xfer(8, 0, v);
        chk("R1", "status after reset", v, 64'h00);
    endtask

    task automatic t_id();
        logic [63:0] v;
        ir_load(8'hFE); dr_xfer(32, 0, v);
        chk("R2", "id capture", v, {32'b0, ID});
    endtask

    task automatic t_program();
        logic [63:0] v; logic [7:0] f, l;
        ir_load(8'h0C); ir_load(8'h10); dr_xfer(8, 0, v);
        chk("R3", "status after enter", v, 64'h08);
        set_addr(8'h01);
        ir_load(8'h20); dr_xfer(64, 64'hFFFF_FFFF_0000_FFFF, v);
        poll(f, l);
        chk("R4", "status while busy", {56'b0, f}, 64'h08);
        chk("R4", "status after completion", {56'b0, l}, 64'h0E);
        set_addr(8'h22);
        run_op(8'h20, 64'h0, l);
        chk("R7", "secondary program status", {56'b0, l}, 64'h0E);
        blank_read(MASK, v);
        chk("R7", "programmed sectors not blank", v, (64'd1 << 1) | (64'd1 << 34));
        blank_read(64'd1 << 34, v);
        chk("R12", "partial mask result", v, 64'd1 << 34);
    endtask

    task automatic t_reject();
        logic [63:0] v; logic [7:0] f, l;
        ir_load(8'h0F); ir_load(8'h10); dr_xfer(8, 0, v);
        chk("R3", "status after leave", v, 64'h06);
        ir_load(8'h30); dr_xfer(64, 64'h2, v);
        poll(f, l);
        chk("R5", "erase rejected without mode", {56'b0, l}, 64'h05);
        ir_load(8'h0C);
        blank_read(MASK, v);
        chk("R5", "sectors unchanged after reject", v, (64'd1 << 1) | (64'd1 << 34));
    endtask

    task automatic t_erase();
        logic [63:0] v; logic [7:0] l;
        run_op(8'h30, 64'h2, l);
        chk("R8", "sector erase status", {56'b0, l}, 64'h0E);
        blank_read(MASK, v);
        chk("R8", "only erased sector blank", v, 64'd1 << 34);
    endtask

    task automatic t_option();
        logic [63:0] v; logic [7:0] l;
        set_addr(8'h50); run_op(8'h20, OPTV, l);
        ir_load(8'h07); dr_xfer(64, 0, v);
        chk("R6", "option readback", v, OPTV);
        set_addr(8'h10); run_op(8'h20, 64'h0, l);
        chk("R7", "unmapped address rejected", {56'b0, l}, 64'h0D);
        ir_load(8'h07); tms_reset(); dr_xfer(8, 0, v);
        chk("R13", "status after tms reset", v, 64'h0D);
        ir_load(8'h07); dr_xfer(64, 0, v);
        chk("R13", "option kept by tms reset", v, OPTV);
        run_op(8'h30, 64'd1 << 49, l);
        ir_load(8'h07); dr_xfer(64, 0, v);
        chk("R10", "option erased", v, 64'h0);
        blank_read(MASK, v);
        chk("R10", "sectors kept by option erase", v, 64'd1 << 34);
    endtask

    task automatic t_secure();
        logic [63:0] v; logic [7:0] f, l;
        set_addr(8'h80); ir_load(8'h22); poll(f, l);
        chk("R11", "security bit set", {56'b0, l}, 64'h4E);
        tms_reset(); dr_xfer(8, 0, v);
        chk("R13", "security kept by tms reset", v, 64'h4E);
        ir_load(8'h13); ir_load(8'h10); dr_xfer(8, 0, v);
        chk("R14", "clear status", v, 64'h4C);
    endtask

    task automatic t_full_erase();
        logic [63:0] v; logic [7:0] l;
        set_addr(8'h50); run_op(8'h20, OPTV, l);
        run_op(8'h30, '1, l);
        chk("R9", "full erase status", {56'b0, l}, 64'h0E);
        ir_load(8'h07); dr_xfer(64, 0, v);
        chk("R9", "option cleared", v, 64'h0);
        blank_read(MASK, v);
        chk("R9", "all sectors blank", v, 64'h0);
    endtask

    initial begin
        #(150000 * 20);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_id();
        t_program();
        t_reject();
        t_erase();
        t_option();
        t_secure();
        t_full_erase();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule